// File: doc/BRIEF.md
# Programmable LCD Timing Generator

This block produces the raster timing for a parallel LCD panel. Software programs, per axis, a sync width, a back porch, an active length and a front porch through a small word-addressed register port. Once the enable field holds the run code, a pixel counter and a line counter sweep the raster. The block derives an active-low horizontal sync, an active-low vertical sync and a data-enable strobe from the two counters.

Both live counters can be read back through the same port. A software window sits inside the active area. It is placed by an X and a Y shift and sized by a software width and height. A separate flag marks the pixels that fall inside it, so a fetch engine elsewhere knows which positions carry software pixels.

Timing values are double-buffered. Writes go to live registers, and these are copied into a working set at the end of each frame, or on every cycle while the engine is stopped. A frame is therefore always drawn with one consistent set of values.

Top module: `lcd_timing_gen`

## Requirements
- R1: Unless word 0x00 bits 1:0 equal 3, both counters are held at 0, `hsync_n` and `vsync_n` stay 1, and `de` and `sw_win` stay 0.
- R2: A write to a configuration word stores its low 12 bits, and reading that word returns them. The words are: 0x10 horizontal back porch, 0x14 horizontal sync width, 0x18 horizontal front porch, 0x1C active width, 0x20 vertical back porch, 0x24 vertical sync width, 0x28 vertical front porch, 0x2C active height, 0x40 Y shift, 0x44 X shift, 0x48 software width and 0x4C software height. Word 0x00 keeps bits 1:0. Any other address reads 0.
- R3: While running, the pixel counter steps by one each clock from 0 up to (sync+back porch+active+front porch)−1 of the horizontal set, then returns to 0. Its value reads back at word 0x34's neighbour, word 0x30.
- R4: The line counter steps by one each time the pixel counter wraps. It returns to 0 after the last line of the vertical total, and its value reads back at word 0x34.
- R5: Each line and frame runs in the order sync, back porch, active, front porch. `hsync_n` is low while the pixel count is below the horizontal sync width. `vsync_n` is low while the line count is below the vertical sync width.
- R6: `de` is 1 exactly when the pixel count lies in [hsync+hbp, hsync+hbp+width) and the line count lies in [vsync+vbp, vsync+vbp+height).
- R7: `sw_win` is 1 when `de` is 1 and both of these hold: the position inside the active area, minus the X shift, lies in [0, software width); and the line inside the active area, minus the Y shift, lies in [0, software height).
- R8: Values written while running take effect on the first cycle of the next frame. While stopped they take effect one cycle after the write.
- R9: Writes to words 0x30 and 0x34 are ignored and leave the counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register word |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data enable for the active area |
| sw_win | output | 1 | Pixel lies inside the shifted software window |

## Verification
A wrong counter value or a wrong working register set shows at the ports in the same cycle. The sync, data-enable and window strobes are decoded combinationally from the counters, and the pixel or line count is visible on the read port. A bench that compares all four strobes and the read data against a behavioural raster model on every clock therefore catches such a fault at its first affected cycle. Faults in the double-buffering only appear at a frame boundary after a mid-frame write, so the stimulus changes timing values mid-frame and runs across the following frame start.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

  localparam int FW    = 12;
  localparam int CNT_W = FW + 2;

  // word indices (byte offset / 4)
  localparam int WI_CTRL  = 0;
  localparam int WI_HBP   = 4;
  localparam int WI_HSY   = 5;
  localparam int WI_HFP   = 6;
  localparam int WI_HACT  = 7;
  localparam int WI_VBP   = 8;
  localparam int WI_VSY   = 9;
  localparam int WI_VFP   = 10;
  localparam int WI_VACT  = 11;
  localparam int WI_HCNT  = 12;
  localparam int WI_VCNT  = 13;
  localparam int WI_YSH   = 16;
  localparam int WI_XSH   = 17;
  localparam int WI_SWW   = 18;
  localparam int WI_SWH   = 19;

  localparam logic [1:0] RUN_CODE = 2'b11;

  typedef struct packed {
    logic [FW-1:0] sync;
    logic [FW-1:0] bp;
    logic [FW-1:0] act;
    logic [FW-1:0] fp;
  } lt_axis_t;

  typedef struct packed {
    logic [FW-1:0] shift;
    logic [FW-1:0] len;
  } lt_win_t;

  function automatic logic [CNT_W-1:0] axis_total(input lt_axis_t c);
    return CNT_W'(c.sync) + CNT_W'(c.bp) + CNT_W'(c.act) + CNT_W'(c.fp);
  endfunction

  function automatic logic [CNT_W-1:0] act_start(input lt_axis_t c);
    return CNT_W'(c.sync) + CNT_W'(c.bp);
  endfunction

  function automatic logic in_span(input logic [CNT_W-1:0] pos,
                                   input logic [CNT_W-1:0] lo,
                                   input logic [FW-1:0]    len);
    logic [CNT_W:0] hi;
    hi = {1'b0, lo} + (CNT_W+1)'(len);
    return ({1'b0, pos} >= {1'b0, lo}) && ({1'b0, pos} < hi);
  endfunction

  function automatic logic win_hit(input logic [CNT_W-1:0] pos,
                                   input logic [FW-1:0]    shift,
                                   input logic [FW-1:0]    len);
    logic [CNT_W-1:0] sh;
    sh = CNT_W'(shift);
    return (pos >= sh) && ((pos - sh) < CNT_W'(len));
  endfunction

endpackage

// File: rtl/lcdt_regs.sv
module lcdt_regs
  import lcdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              load,
  input  logic [CNT_W-1:0]  hcnt,
  input  logic [CNT_W-1:0]  vcnt,
  output logic              run,
  output lt_axis_t          h_shd,
  output lt_axis_t          v_shd,
  output lt_win_t           hw_shd,
  output lt_win_t           vw_shd,
  output logic [DATA_W-1:0] rdata
);

  localparam int WIDX_W = ADDR_W - 2;

  logic              aligned;
  logic [WIDX_W-1:0] widx;
  logic [FW-1:0]     wfield;
  logic              unused_wdata_hi;

  logic [1:0] ctrl_q;
  lt_axis_t   h_live, v_live;
  lt_win_t    hw_live, vw_live;

  assign aligned         = (addr[1:0] == 2'b00);
  assign widx            = addr[ADDR_W-1:2];
  assign wfield          = wdata[FW-1:0];
  assign unused_wdata_hi = &{1'b0, wdata[DATA_W-1:FW]};
  assign run             = (ctrl_q == RUN_CODE);

  // live register set, written by software
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      h_live  <= '0;
      v_live  <= '0;
      hw_live <= '0;
      vw_live <= '0;
    end else if (we && aligned) begin
      case (int'(widx))
        WI_CTRL: ctrl_q        <= wdata[1:0];
        WI_HBP:  h_live.bp     <= wfield;
        WI_HSY:  h_live.sync   <= wfield;
        WI_HFP:  h_live.fp     <= wfield;
        WI_HACT: h_live.act    <= wfield;
        WI_VBP:  v_live.bp     <= wfield;
        WI_VSY:  v_live.sync   <= wfield;
        WI_VFP:  v_live.fp     <= wfield;
        WI_VACT: v_live.act    <= wfield;
        WI_YSH:  vw_live.shift <= wfield;
        WI_XSH:  hw_live.shift <= wfield;
        WI_SWW:  hw_live.len   <= wfield;
        WI_SWH:  vw_live.len   <= wfield;
        default: ;
      endcase
    end
  end

  // working set, copied at frame end or while stopped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_shd  <= '0;
      v_shd  <= '0;
      hw_shd <= '0;
      vw_shd <= '0;
    end else if (load) begin
      h_shd  <= h_live;
      v_shd  <= v_live;
      hw_shd <= hw_live;
      vw_shd <= vw_live;
    end
  end

  always_comb begin
    rdata = '0;
    if (aligned) begin
      case (int'(widx))
        WI_CTRL: rdata = DATA_W'(ctrl_q);
        WI_HBP:  rdata = DATA_W'(h_live.bp);
        WI_HSY:  rdata = DATA_W'(h_live.sync);
        WI_HFP:  rdata = DATA_W'(h_live.fp);
        WI_HACT: rdata = DATA_W'(h_live.act);
        WI_VBP:  rdata = DATA_W'(v_live.bp);
        WI_VSY:  rdata = DATA_W'(v_live.sync);
        WI_VFP:  rdata = DATA_W'(v_live.fp);
        WI_VACT: rdata = DATA_W'(v_live.act);
        WI_HCNT: rdata = DATA_W'(hcnt);
        WI_VCNT: rdata = DATA_W'(vcnt);
        WI_YSH:  rdata = DATA_W'(vw_live.shift);
        WI_XSH:  rdata = DATA_W'(hw_live.shift);
        WI_SWW:  rdata = DATA_W'(hw_live.len);
        WI_SWH:  rdata = DATA_W'(vw_live.len);
        default: rdata = '0;
      endcase
    end
  end

  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(h_shd) && $stable(v_shd) && $stable(hw_shd) && $stable(vw_shd)));

endmodule

// File: rtl/lcdt_axis.sv
module lcdt_axis
  import lcdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             step,
  input  lt_axis_t         cfg,
  input  lt_win_t          win,
  output logic [CNT_W-1:0] cnt,
  output logic             last,
  output logic             sync_on,
  output logic             act_on,
  output logic             win_on
);

  logic [CNT_W-1:0] total;
  logic [CNT_W-1:0] a_start;
  logic [CNT_W:0]   nxt;

  assign total   = axis_total(cfg);
  assign a_start = act_start(cfg);
  assign nxt     = {1'b0, cnt} + 1'b1;
  assign last    = (nxt >= {1'b0, total});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (step)   cnt <= last ? '0 : nxt[CNT_W-1:0];
  end

  assign sync_on = (cnt < CNT_W'(cfg.sync));
  assign act_on  = in_span(cnt, a_start, cfg.act);
  assign win_on  = act_on && win_hit(cnt - a_start, win.shift, win.len);

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (total != '0)) |-> (cnt < total));

  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              de,
  output logic              sw_win
);

  logic             run, load;
  lt_axis_t         h_shd, v_shd;
  lt_win_t          hw_shd, vw_shd;
  logic [CNT_W-1:0] h_cnt, v_cnt;
  logic             h_last, v_last, h_wrap, frame_end;
  logic             h_sync_on, v_sync_on, h_act_on, v_act_on, h_win_on, v_win_on;

  assign h_wrap    = run && h_last;
  assign frame_end = h_wrap && v_last;
  assign load      = !run || frame_end;

  lcdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .load(load), .hcnt(h_cnt), .vcnt(v_cnt), .run(run),
    .h_shd(h_shd), .v_shd(v_shd), .hw_shd(hw_shd), .vw_shd(vw_shd),
    .rdata(reg_rdata)
  );

  lcdt_axis u_hax (
    .clk(clk), .rst_n(rst_n), .run(run), .step(1'b1), .cfg(h_shd), .win(hw_shd),
    .cnt(h_cnt), .last(h_last), .sync_on(h_sync_on), .act_on(h_act_on), .win_on(h_win_on)
  );

  lcdt_axis u_vax (
    .clk(clk), .rst_n(rst_n), .run(run), .step(h_wrap), .cfg(v_shd), .win(vw_shd),
    .cnt(v_cnt), .last(v_last), .sync_on(v_sync_on), .act_on(v_act_on), .win_on(v_win_on)
  );

  assign hsync_n = !(run && h_sync_on);
  assign vsync_n = !(run && v_sync_on);
  assign de      = run && h_act_on && v_act_on;
  assign sw_win  = de && h_win_on && v_win_on;

  // R4
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !h_wrap) |=> $stable(v_cnt));

  // R5
  sync_outside_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (hsync_n && vsync_n));

  // R7
  window_in_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_win |-> de);

  // R1
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (hsync_n && vsync_n && !de && !sw_win));

endmodule

// File: tb/tb_lcd_timing_gen.sv
`timescale 1ns/1ps
module tb_lcd_timing_gen;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  wire  [31:0] reg_rdata;
  wire         hsync_n, vsync_n, de, sw_win;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int lv[20];
  int sv[20];
  int hc, vc;

  always #2.5 clk = ~clk;

  lcd_timing_gen dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de), .sw_win(sw_win)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit is_cfg(input int i);
    return (i == 0) || (i >= 4 && i <= 11) || (i >= 16 && i <= 19);
  endfunction

  function automatic int exp_rdata(input int a);
    int i;
    i = a / 4;
    if (a % 4 != 0) return 0;
    if (i == 12) return hc;
    if (i == 13) return vc;
    if (i < 20 && is_cfg(i)) return lv[i];
    return 0;
  endfunction

  // behavioural raster model: lv = written values, sv = frame working set
  always @(posedge clk) begin : model
    if (!rst_n) begin
      foreach (lv[k]) begin lv[k] = 0; sv[k] = 0; end
      hc = 0; vc = 0;
    end else begin
      bit running, hl, vl, fend;
      int ht, vt, idx;
      running = (lv[0] == 3);
      ht = sv[4] + sv[5] + sv[6] + sv[7];
      vt = sv[8] + sv[9] + sv[10] + sv[11];
      hl = (hc + 1 >= ht);
      vl = (vc + 1 >= vt);
      fend = running && hl && vl;
      if (!running) begin
        hc = 0; vc = 0;
      end else begin
        if (hl) begin
          hc = 0;
          vc = vl ? 0 : vc + 1;
        end else hc = hc + 1;
      end
      if (!running || fend) foreach (sv[k]) sv[k] = lv[k];
      idx = reg_addr / 4;
      if (reg_we && (reg_addr % 4 == 0) && idx < 20 && is_cfg(idx))
        lv[idx] = (idx == 0) ? (reg_wdata & 3) : (reg_wdata & 4095);
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit running, hact, vact, e_de, e_win;
      int hs0, vs0, er;
      string rq;
      running = (lv[0] == 3);
      hs0  = sv[5] + sv[4];
      vs0  = sv[9] + sv[8];
      hact = (hc >= hs0) && (hc < hs0 + sv[7]);
      vact = (vc >= vs0) && (vc < vs0 + sv[11]);
      e_de = running && hact && vact;
      e_win = e_de && (hc - hs0 >= sv[17]) && (hc - hs0 - sv[17] < sv[18])
                   && (vc - vs0 >= sv[16]) && (vc - vs0 - sv[16] < sv[19]);
      check(hsync_n == !(running && hc < sv[5]), "R5", "hsync_n",
            hsync_n, !(running && hc < sv[5]));
      check(vsync_n == !(running && vc < sv[9]), "R5", "vsync_n",
            vsync_n, !(running && vc < sv[9]));
      check(de == e_de, "R6", "de", de, e_de);
      check(sw_win == e_win, "R7", "sw_win", sw_win, e_win);
      er = exp_rdata(reg_addr);
      rq = (reg_addr == 8'h30) ? "R3 R8 R9" : (reg_addr == 8'h34) ? "R4" : "R2";
      check(reg_rdata == 32'(er), rq, $sformatf("rdata@%02h", reg_addr), reg_rdata, er);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0; reg_addr = 8'h30;
  endtask

  task automatic run_cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      reg_addr = (i % 2 == 1) ? 8'h34 : 8'h30;
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 8'h30; reg_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(hsync_n == 1'b1 && vsync_n == 1'b1, "R1", "syncs after reset", {hsync_n, vsync_n}, 3);
    check(de == 1'b0 && sw_win == 1'b0, "R1", "de/win after reset", {de, sw_win}, 0);
    check(reg_rdata == 0, "R1", "hcnt after reset", reg_rdata, 0);

    // horizontal 2+3+8+2 = 15, vertical 1+2+4+1 = 8
    wr(8'h14, 2); wr(8'h10, 3); wr(8'h1C, 8); wr(8'h18, 2);
    wr(8'h24, 1); wr(8'h20, 2); wr(8'h2C, 4); wr(8'h28, 1);
    wr(8'h44, 2); wr(8'h40, 1); wr(8'h48, 4); wr(8'h4C, 2);
    wr(8'h1C, 32'hFFFF_F008);  // upper bits dropped (R2)
    for (int a = 0; a < 8'h54; a += 4) begin
      @(posedge clk); #1 reg_addr = 8'(a);
    end
    @(posedge clk); #1 reg_addr = 8'h1C;
    @(negedge clk);
    check(reg_rdata == 32'd8, "R2", "active width readback", reg_rdata, 8);
    check(de == 1'b0, "R1", "de before enable", de, 0);

    wr(8'h00, 3);
    run_cyc(260);
    // mid-frame change: applies from next frame (R8)
    run_cyc(37);
    wr(8'h1C, 5); wr(8'h18, 4);
    run_cyc(300);

    // R9: counter words are read-only
    wr(8'h30, 32'h0AB);
    @(negedge clk);
    check(reg_rdata == 32'(hc), "R9", "hcnt after write", reg_rdata, hc);
    wr(8'h34, 32'h5);
    run_cyc(150);

    // window covering whole active area
    wr(8'h44, 0); wr(8'h40, 0); wr(8'h48, 4095); wr(8'h4C, 4095);
    run_cyc(300);

    // boundary: zero back porch, window shifted to the last pixel/line
    wr(8'h10, 0); wr(8'h44, 4); wr(8'h40, 3); wr(8'h48, 1); wr(8'h4C, 1);
    run_cyc(300);

    // R1: code 2 is not the run code
    wr(8'h00, 2);
    run_cyc(4);
    @(negedge clk);
    check(reg_rdata == 0, "R1", "counter while stopped", reg_rdata, 0);
    check(de == 1'b0 && hsync_n == 1'b1, "R1", "outputs while stopped", {de, hsync_n}, 1);

    // R8 while stopped: new value used immediately on restart
    wr(8'h14, 1);
    wr(8'h00, 32'h7);
    run_cyc(300);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule